// File: doc/BRIEF.md
# USB Start-of-Frame Number Capture

This block sits behind a device-side USB packet decoder and follows the Start-of-Frame traffic that the host sends once per frame. The decoder hands it already unstuffed packet bytes. A one-cycle start strobe marks a new packet, and the first byte of the packet, which may arrive in that same cycle, is the PID. A valid strobe qualifies each byte, and an end strobe closes the packet. When the PID is the SOF token, the block raises a one-cycle interrupt at once. It then gathers the 11-bit frame number and its 5-bit CRC and checks the CRC when the packet ends.

The CPU sees two read-only byte registers. The low register carries frame-number bits 7..0. The high register carries frame-number bits 10..8 together with a "last SOF good" flag and a "last SOF corrupted" flag. The frame number is taken only from an SOF whose CRC checks. The two flags are rewritten by every SOF, whether it is good or bad. The interrupt therefore tells software that a frame has begun, before the block knows whether that frame's number can be trusted.

Top module: `usb_sof_capture`

## Requirements
- R1: After reset, both register outputs read 8'h00 and the interrupt output is low.
- R2: A PID byte of 8'hA5 received as the first byte of a packet drives sof_irq high for exactly the one cycle after that byte is sampled, independent of what follows.
- R3: A first byte other than 8'hA5 (another token, or a byte whose upper nibble is not the complement of its lower nibble) raises no interrupt, and the rest of that packet leaves both registers unchanged.
- R4: An SOF whose CRC checks good loads frame[7:0] into reg_lo and frame[10:8] into reg_hi bits 2..0, sets reg_hi bit 5 and clears bit 4; the new values are visible from the second clock edge after the end strobe is sampled.
- R5: An SOF whose CRC fails sets reg_hi bit 4, clears bit 5 and keeps the stored frame number.
- R6: An SOF that ends with fewer than two bytes after the PID counts as corrupted (bit 4 set, bit 5 cleared, frame number kept).
- R7: An SOF with more than two bytes after the PID counts as corrupted.
- R8: reg_hi bits 7, 6 and 3 always read 0.
- R9: A start strobe that arrives while an SOF is still open ends that SOF as corrupted.
- R10: Bytes that arrive outside an open packet are ignored: no interrupt and no register change.
- R11: After the PID, the first byte holds frame[7:0]. The second byte holds frame[10:8] in bits 2..0 and the CRC field in bits 7..3. The CRC is the complemented remainder for x^5+x^2+1 with a preset of all ones, sent MSB first starting at bit 3. A good packet run through the same register leaves 5'b01100.
- R12: An end strobe sampled together with a byte counts that byte as part of the packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | New packet begins; a byte in the same cycle is its PID |
| byte_valid | input | 1 | byte_data holds a packet byte |
| byte_data | input | 8 | Decoded packet byte |
| pkt_end | input | 1 | Packet ends after any byte in this cycle |
| sof_irq | output | 1 | One-cycle pulse when an SOF PID arrives |
| reg_lo | output | 8 | Frame number bits 7..0 |
| reg_hi | output | 8 | {2'b0, good, corrupted, 1'b0, frame[10:8]} |

## Verification
The cases that are hardest to reach from the ports are the ones where the packet boundaries disagree with the byte count. These are an SOF cut short by a fresh start strobe, an end strobe that lands on the same cycle as the last byte, and packets that run one byte long. Directed sequences build each of these after a known-good frame number has been stored, so that a wrongly kept or wrongly taken frame number shows up. Random rounds then mix good SOFs, single-bit CRC corruption, truncation, overlength packets and other tokens, with the end strobe placed at random.

// File: rtl/sof_pkg.sv
package sof_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          FRAME_W    = 11;
    localparam int          CRC_W      = 5;
    localparam int          FIELD_W    = FRAME_W + CRC_W;
    localparam int          HI_FRAME_W = FRAME_W - BYTE_W;
    localparam int          CNT_W      = 2;
    localparam logic [7:0]  PID_SOF    = 8'hA5;
    localparam logic [4:0]  CRC_POLY   = 5'b00101;
    localparam logic [4:0]  CRC_INIT   = 5'b11111;
    localparam logic [4:0]  CRC_RESID  = 5'b01100;
    localparam int          HI_GOOD_BIT = 5;
    localparam int          HI_BAD_BIT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PID  = 2'd1,
        ST_SOF  = 2'd2,
        ST_SKIP = 2'd3
    } parse_state_e;

    typedef struct packed {
        parse_state_e            st;
        logic [CNT_W-1:0]        cnt;
        logic [BYTE_W-1:0]       b0;
        logic [BYTE_W-1:0]       b1;
        logic                    irq;
        logic                    res_valid;
        logic                    res_good;
        logic [FRAME_W-1:0]      res_frame;
    } parse_regs_t;

    typedef struct packed {
        logic [FRAME_W-1:0]      frame;
        logic                    good;
        logic                    bad;
    } frame_regs_t;
endpackage

// File: rtl/sof_crc5_check.sv
module sof_crc5_check
    import sof_pkg::*;
#(
    parameter int DATA_W = FIELD_W
) (
    input  logic [DATA_W-1:0] bits_i,
    output logic              ok_o
);
    logic [CRC_W-1:0] rem_d;

    always_comb begin
        rem_d = CRC_INIT;
        for (int i = 0; i < DATA_W; i++) begin
            if (bits_i[i] ^ rem_d[CRC_W-1]) begin
                rem_d = {rem_d[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            end else begin
                rem_d = {rem_d[CRC_W-2:0], 1'b0};
            end
        end
        ok_o = (rem_d == CRC_RESID);
    end
endmodule

// File: rtl/sof_pkt_parser.sv
module sof_pkt_parser
    import sof_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_start_i,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_data_i,
    input  logic               pkt_end_i,
    output logic               sof_irq_o,
    output logic               res_valid_o,
    output logic               res_good_o,
    output logic [FRAME_W-1:0] res_frame_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    parse_regs_t  r_q, r_d;
    parse_state_e cur_st;
    logic         abort;
    logic         fin;
    logic         crc_ok;
    logic [FIELD_W-1:0] field_d;

    assign field_d = {r_d.b1, r_d.b0};

    sof_crc5_check #(.DATA_W(FIELD_W)) crc_i (
        .bits_i (field_d),
        .ok_o   (crc_ok)
    );

    always_comb begin
        r_d           = r_q;
        r_d.irq       = 1'b0;
        r_d.res_valid = 1'b0;
        r_d.res_good  = 1'b0;
        cur_st        = r_q.st;
        abort         = 1'b0;
        if (pkt_start_i) begin
            abort   = (r_q.st == ST_SOF);
            cur_st  = ST_PID;
            r_d.cnt = '0;
        end
        r_d.st = cur_st;
        if (byte_valid_i) begin
            case (cur_st)
                ST_PID: begin
                    if (byte_data_i == PID_SOF) begin
                        r_d.st  = ST_SOF;
                        r_d.cnt = '0;
                        r_d.irq = 1'b1;
                    end else begin
                        r_d.st = ST_SKIP;
                    end
                end
                ST_SOF: begin
                    if (r_d.cnt == CNT_W'(0)) r_d.b0 = byte_data_i;
                    if (r_d.cnt == CNT_W'(1)) r_d.b1 = byte_data_i;
                    if (r_d.cnt != CNT_MAX)   r_d.cnt = r_d.cnt + 1'b1;
                end
                default: ;
            endcase
        end
        fin = pkt_end_i && (r_d.st == ST_SOF);
        if (pkt_end_i) r_d.st = ST_IDLE;
        r_d.res_valid = abort | fin;
        r_d.res_good  = fin && !abort && (r_d.cnt == CNT_W'(2)) && crc_ok;
        r_d.res_frame = {r_d.b1[HI_FRAME_W-1:0], r_d.b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sof_irq_o   = r_q.irq;
    assign res_valid_o = r_q.res_valid;
    assign res_good_o  = r_q.res_good;
    assign res_frame_o = r_q.res_frame;

    // R2: a pulse only ever follows a sampled SOF PID byte
    p_irq_after_pid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_irq_o |-> $past(byte_valid_i && byte_data_i == PID_SOF))
        else $error("p_irq_after_pid_r2");

    // R10: a byte outside any packet never raises the interrupt
    p_no_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !pkt_start_i && byte_valid_i) |=> !sof_irq_o)
        else $error("p_no_irq_idle_r10");

    // R9: a start while an SOF is open produces a failing result
    p_abort_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SOF && pkt_start_i) |=> (res_valid_o && !res_good_o))
        else $error("p_abort_bad_r9");
endmodule

// File: rtl/sof_frame_regs.sv
module sof_frame_regs
    import sof_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_valid_i,
    input  logic               res_good_i,
    input  logic [FRAME_W-1:0] res_frame_i,
    output logic [BYTE_W-1:0]  reg_lo_o,
    output logic [BYTE_W-1:0]  reg_hi_o
);
    frame_regs_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (res_valid_i) begin
            f_d.good = res_good_i;
            f_d.bad  = !res_good_i;
            if (res_good_i) f_d.frame = res_frame_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        reg_lo_o              = f_q.frame[BYTE_W-1:0];
        reg_hi_o              = '0;
        reg_hi_o[HI_FRAME_W-1:0] = f_q.frame[FRAME_W-1:BYTE_W];
        reg_hi_o[HI_GOOD_BIT] = f_q.good;
        reg_hi_o[HI_BAD_BIT]  = f_q.bad;
    end

    // R5: a failing result keeps the stored frame number
    p_frame_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && !res_good_i) |=> $stable(f_q.frame))
        else $error("p_frame_hold_r5");

    // R4: a passing result loads the candidate frame number
    p_good_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && res_good_i) |=> (f_q.frame == $past(res_frame_i)))
        else $error("p_good_loads_r4");

    // R5: the error flag follows the last result
    p_flag_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i |=> (f_q.bad == !$past(res_good_i)))
        else $error("p_flag_follow_r5");

    // R4: the two flags are never set together
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({f_q.good, f_q.bad}))
        else $error("p_flags_excl_r4");
endmodule

// File: rtl/usb_sof_capture.sv
module usb_sof_capture
    import sof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pkt_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       pkt_end,
    output logic       sof_irq,
    output logic [7:0] reg_lo,
    output logic [7:0] reg_hi
);
    logic               res_valid;
    logic               res_good;
    logic [FRAME_W-1:0] res_frame;

    sof_pkt_parser parser_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_start_i  (pkt_start),
        .byte_valid_i (byte_valid),
        .byte_data_i  (byte_data),
        .pkt_end_i    (pkt_end),
        .sof_irq_o    (sof_irq),
        .res_valid_o  (res_valid),
        .res_good_o   (res_good),
        .res_frame_o  (res_frame)
    );

    sof_frame_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid_i (res_valid),
        .res_good_i  (res_good),
        .res_frame_i (res_frame),
        .reg_lo_o    (reg_lo),
        .reg_hi_o    (reg_hi)
    );
endmodule

// File: tb/usb_sof_capture_tb_top.sv
module usb_sof_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       pkt_end = 1'b0;
    logic       sof_irq;
    logic [7:0] reg_lo;
    logic [7:0] reg_hi;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    logic [10:0] exp_fn = '0;
    logic        exp_good = 1'b0;
    logic        exp_bad = 1'b0;
    logic [7:0]  pk [0:4];

    always #2 clk = ~clk;

    usb_sof_capture dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .pkt_end(pkt_end), .sof_irq(sof_irq),
        .reg_lo(reg_lo), .reg_hi(reg_hi)
    );

    always @(posedge clk) if (rst_n && sof_irq) irq_cnt <= irq_cnt + 1;

    function automatic logic [4:0] crc_field(input logic [10:0] fn);
        logic [4:0] c = 5'h1f;
        for (int i = 0; i < 11; i++) begin
            if (fn[i] ^ c[4]) c = {c[3:0], 1'b0} ^ 5'b00101;
            else              c = {c[3:0], 1'b0};
        end
        c = ~c;
        return {c[0], c[1], c[2], c[3], c[4]};
    endfunction

    function automatic logic [7:0] hi_byte(input logic [10:0] fn);
        return {fn[10:8] == 3'b000 ? 5'b0 : 5'b0, 3'b000} | {crc_field(fn), fn[10:8]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " lo"}, reg_lo, exp_fn[7:0]);
        check({req, " hi R8"}, reg_hi, {2'b00, exp_good, exp_bad, 1'b0, exp_fn[10:8]});
    endtask

    // drive n bytes from pk; end with last byte or in a separate cycle
    task automatic send(input int n, input bit end_on_last, input bit with_end);
        for (int i = 0; i < n; i++) begin
            pkt_start  = (i == 0);
            byte_valid = 1'b1;
            byte_data  = pk[i];
            pkt_end    = with_end && end_on_last && (i == n - 1);
            @(negedge clk);
        end
        pkt_start = 1'b0; byte_valid = 1'b0; pkt_end = 1'b0;
        if (with_end && !end_on_last) begin
            pkt_end = 1'b1;
            @(negedge clk);
            pkt_end = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic load_sof(input logic [10:0] fn);
        pk[0] = 8'hA5; pk[1] = fn[7:0]; pk[2] = hi_byte(fn);
    endtask

    task automatic expect_result(input bit good, input logic [10:0] fn);
        exp_good = good; exp_bad = !good;
        if (good) exp_fn = fn;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 irq", sof_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1");
        check("R1 irq after", sof_irq, 0);

        // R2 / R4: good SOF, interrupt right after PID
        load_sof(11'h5A3);
        pkt_start = 1; byte_valid = 1; byte_data = 8'hA5;
        @(negedge clk);
        check("R2 pulse", sof_irq, 1);
        pkt_start = 0; byte_data = pk[1];
        @(negedge clk);
        check("R2 one cycle", sof_irq, 0);
        byte_data = pk[2]; pkt_end = 1;
        @(negedge clk);
        byte_valid = 0; pkt_end = 0;
        check("R4 not yet", reg_lo, 8'h00);
        @(negedge clk);
        expect_result(1, 11'h5A3);
        check_regs("R4 R11 R12");

        // R5: single-bit CRC error
        load_sof(11'h0F0); pk[2] = pk[2] ^ 8'h40;
        send(3, 0, 1); settle();
        expect_result(0, 0);
        check_regs("R5");

        // R4: all-ones frame
        load_sof(11'h7FF); send(3, 1, 1); settle();
        expect_result(1, 11'h7FF);
        check_regs("R4 max");

        // R6: truncated after one data byte
        load_sof(11'h001); base = irq_cnt;
        send(2, 1, 1); settle();
        expect_result(0, 0);
        check_regs("R6 short");
        check("R6 irq still", irq_cnt - base, 1);

        // R6: PID only
        load_sof(11'h002); send(1, 0, 1); settle();
        check_regs("R6 pid only");

        // R4 restore good, then R7 overlength
        load_sof(11'h123); send(3, 0, 1); settle();
        expect_result(1, 11'h123); check_regs("R4 again");
        load_sof(11'h456); pk[3] = 8'h00; send(4, 1, 1); settle();
        expect_result(0, 0);
        check_regs("R7");

        // R9: SOF left open, then new start with an IN token
        load_sof(11'h321); send(3, 0, 1); settle();
        expect_result(1, 11'h321);
        load_sof(11'h654); send(2, 0, 0);
        pk[0] = 8'h69; pk[1] = 8'h00; pk[2] = 8'h00;
        send(3, 1, 1); settle();
        expect_result(0, 0);
        check_regs("R9");

        // R3: bad-complement PID and another token with SOF-like bytes
        load_sof(11'h7AA); send(3, 1, 1); settle();
        expect_result(1, 11'h7AA);
        base = irq_cnt;
        load_sof(11'h055); pk[0] = 8'hA4; send(3, 1, 1); settle();
        check("R3 no irq", irq_cnt - base, 0);
        check_regs("R3 bad pid");
        load_sof(11'h055); pk[0] = 8'hE1; send(3, 0, 1); settle();
        check_regs("R3 other token");

        // R10: loose bytes between packets
        base = irq_cnt;
        byte_valid = 1; byte_data = 8'hA5; @(negedge clk);
        byte_data = 8'h11; @(negedge clk);
        byte_data = 8'h22; pkt_end = 1; @(negedge clk);
        byte_valid = 0; pkt_end = 0; settle();
        check("R10 no irq", irq_cnt - base, 0);
        check_regs("R10");

        // random rounds
        for (int k = 0; k < 80; k++) begin
            int kind = $urandom % 7;
            logic [10:0] fn = 11'($urandom);
            bit eol = 1'($urandom);
            base = irq_cnt;
            load_sof(fn);
            case (kind)
                3: begin
                    int b = $urandom % 16;
                    if (b < 8) pk[1][b] = ~pk[1][b]; else pk[2][b-8] = ~pk[2][b-8];
                    send(3, eol, 1); expect_result(0, 0);
                end
                4: begin send(1 + ($urandom % 2), eol, 1); expect_result(0, 0); end
                5: begin pk[3] = 8'($urandom); send(4, eol, 1); expect_result(0, 0); end
                6: begin pk[0] = 8'h2D; send(3, eol, 1); end
                default: begin send(3, eol, 1); expect_result(1, fn); end
            endcase
            settle();
            check_regs("R11 random");
            check("R2 random irq", irq_cnt - base, (kind == 6) ? 0 : 1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule